// File: doc/BRIEF.md
# Network Interrupt Aggregator

This block collects interrupt requests from network modules sitting in expansion slots and folds them into one interrupt line toward the processor. Each slot owns a run of bits inside one of two 16-bit status words. A synthesis-time slot table assigns each slot its word and its starting bit. The port number selects a bit within that run. Status bits are active-low, so a word holding all ones means nothing is pending in it.

Module-side logic drives two request channels, one to raise and one to retire. Each request carries a slot index and a port index. The processor reads the two status words through a small read port at fixed addresses, and reading never alters them. The combined interrupt stays asserted for as long as either word differs from all ones.

Top module: `netirq_agg`

## Requirements
- R1: After reset both status words read 0xFFFF, `irq` is low and `rd_data` is 0.
- R2: A raise request (`set_vld`) for slot s, port p clears bit (offset(s) + p) of status word reg(s) at the next clock edge. With the default table, slot 0 uses word 0 at offset 0 and slot 1 uses word 1 at offset 0.
- R3: A retire request (`clr_vld`) for slot s, port p sets that same bit back to 1 at the next clock edge.
- R4: When a raise and a retire hit the same bit in the same cycle, the bit ends up 0 (pending). When they hit different bits, both take effect.
- R5: `irq` is a register. It goes high one cycle after either status word first differs from 0xFFFF. It goes low one cycle after both words are 0xFFFF again.
- R6: A read (`rd_en`) at address 0x26 returns word 0, and at 0x28 returns word 1. The value appears on `rd_data` after the next clock edge and holds until the next read. A read at any other address returns 0.
- R7: Reads have no effect on either status word or on `irq`.
- R8: The following requests are ignored: a slot index of NUM_SLOTS or above, a port index of PORTS_PER_SLOT or above (default 16; the port field is 5 bits wide), and any bit position past the word width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | 1 | Raise request strobe |
| set_slot | input | 2 | Slot index of the raise request |
| set_port | input | 5 | Port index of the raise request |
| clr_vld | input | 1 | Retire request strobe |
| clr_slot | input | 2 | Slot index of the retire request |
| clr_port | input | 5 | Port index of the retire request |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A request sampled at edge N changes the status word at edge N. `irq` follows one edge later, at N+1. A read sampled at the same edge N+1 returns the word as it stood after edge N. The bench drives all inputs at falling edges and reads each result at the falling edge after the edge where it is due. The interrupt-timing test also looks at the falling edge between N and N+1, where `irq` must still hold its old value. That pins the one-cycle register on `irq` exactly, rather than only checking that the change arrives eventually.

// File: rtl/netirq_pkg.sv
package netirq_pkg;

    localparam int unsigned TAB_FIELD_W  = 8;
    localparam int unsigned TAB_MAX_BITS = 256;

    // Extract one 8-bit slot-table field.
    function automatic int unsigned tab_field(input logic [TAB_MAX_BITS-1:0] tab,
                                              input int unsigned idx);
        return 32'(tab[idx*TAB_FIELD_W +: TAB_FIELD_W]);
    endfunction

endpackage

// File: rtl/netirq_decode.sv
module netirq_decode
    import netirq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS      = 2,
    parameter int unsigned NUM_REGS       = 2,
    parameter int unsigned WORD_W         = 16,
    parameter int unsigned SLOT_W         = 2,
    parameter int unsigned PORT_W         = 5,
    parameter int unsigned PORTS_PER_SLOT = 16,
    parameter logic [NUM_SLOTS*TAB_FIELD_W-1:0] SLOT_REG_TAB = '0,
    parameter logic [NUM_SLOTS*TAB_FIELD_W-1:0] SLOT_OFF_TAB = '0
) (
    input  logic                       vld,
    input  logic [SLOT_W-1:0]          slot,
    input  logic [PORT_W-1:0]          port,
    output logic [NUM_REGS*WORD_W-1:0] mask
);

    localparam int unsigned NW = NUM_REGS * WORD_W;

    logic [NW-1:0] slot_mask [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int unsigned REG_IDX = tab_field(TAB_MAX_BITS'(SLOT_REG_TAB), s);
        localparam int unsigned BIT_OFF = tab_field(TAB_MAX_BITS'(SLOT_OFF_TAB), s);

        if (REG_IDX < NUM_REGS) begin : g_mapped
            always_comb begin
                int pos;
                slot_mask[s] = '0;
                pos = int'(BIT_OFF) + int'(port);
                if (vld && (slot == SLOT_W'(s)) && (int'(port) < int'(PORTS_PER_SLOT))
                    && (pos < int'(WORD_W))) begin
                    slot_mask[s][int'(REG_IDX*WORD_W) + pos] = 1'b1;
                end
            end
        end else begin : g_unmapped
            assign slot_mask[s] = '0;
        end
    end

    always_comb begin
        mask = '0;
        for (int s = 0; s < int'(NUM_SLOTS); s++) begin
            mask = mask | slot_mask[s];
        end
    end

endmodule

// File: rtl/netirq_status.sv
module netirq_status #(
    parameter int unsigned NUM_REGS = 2,
    parameter int unsigned WORD_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS*WORD_W-1:0] set_mask,
    input  logic [NUM_REGS*WORD_W-1:0] clr_mask,
    output logic [NUM_REGS*WORD_W-1:0] words
);

    localparam int unsigned NW = NUM_REGS * WORD_W;

    typedef struct packed {
        logic [NW-1:0] words;
    } st_t;

    st_t st_d, st_q;

    // Active-low: retire raises the bit, raise drops it; raise wins a tie.
    always_comb begin
        st_d       = st_q;
        st_d.words = (st_q.words | clr_mask) & ~set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.words <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.words;

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (words == '1));

    a_r7_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask == '0) && (clr_mask == '0)) |=> $stable(words));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
        a_r2_raise_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (set_mask[r*WORD_W +: WORD_W] != '0) |=>
            ((words[r*WORD_W +: WORD_W] & $past(set_mask[r*WORD_W +: WORD_W])) == '0));

        a_r3_retire_lands: assert property (@(posedge clk) disable iff (!rst_n)
            ((clr_mask[r*WORD_W +: WORD_W] & ~set_mask[r*WORD_W +: WORD_W]) != '0) |=>
            ((~words[r*WORD_W +: WORD_W] &
              $past(clr_mask[r*WORD_W +: WORD_W] & ~set_mask[r*WORD_W +: WORD_W])) == '0));
    end

endmodule

// File: rtl/netirq_regif.sv
module netirq_regif #(
    parameter int unsigned NUM_REGS   = 2,
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned REG_BASE   = 'h26,
    parameter int unsigned REG_STRIDE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS*WORD_W-1:0] words,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [WORD_W-1:0]          rd_data
);

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.data = '0;
            for (int r = 0; r < int'(NUM_REGS); r++) begin
                if (rd_addr == ADDR_W'(REG_BASE + r*REG_STRIDE)) begin
                    rd_d.data = words[r*WORD_W +: WORD_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q.data <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q.data;

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r6_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == ADDR_W'(REG_BASE))) |=> (rd_data == $past(words[WORD_W-1:0])));

endmodule

// File: rtl/netirq_agg.sv
module netirq_agg
    import netirq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS      = 2,
    parameter int unsigned NUM_REGS       = 2,
    parameter int unsigned WORD_W         = 16,
    parameter int unsigned SLOT_W         = 2,
    parameter int unsigned PORT_W         = 5,
    parameter int unsigned PORTS_PER_SLOT = 16,
    parameter int unsigned ADDR_W         = 8,
    parameter int unsigned REG_BASE       = 'h26,
    parameter int unsigned REG_STRIDE     = 2,
    parameter logic [NUM_SLOTS*TAB_FIELD_W-1:0] SLOT_REG_TAB = {8'd1, 8'd0},
    parameter logic [NUM_SLOTS*TAB_FIELD_W-1:0] SLOT_OFF_TAB = {8'd0, 8'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic [PORT_W-1:0] set_port,
    input  logic              clr_vld,
    input  logic [SLOT_W-1:0] clr_slot,
    input  logic [PORT_W-1:0] clr_port,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq
);

    localparam int unsigned NW = NUM_REGS * WORD_W;

    logic [NW-1:0]       set_mask, clr_mask, words;
    logic [NUM_REGS-1:0] pend;

    netirq_decode #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS), .WORD_W(WORD_W),
        .SLOT_W(SLOT_W), .PORT_W(PORT_W), .PORTS_PER_SLOT(PORTS_PER_SLOT),
        .SLOT_REG_TAB(SLOT_REG_TAB), .SLOT_OFF_TAB(SLOT_OFF_TAB)
    ) u_set_dec (
        .vld(set_vld), .slot(set_slot), .port(set_port), .mask(set_mask)
    );

    netirq_decode #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS), .WORD_W(WORD_W),
        .SLOT_W(SLOT_W), .PORT_W(PORT_W), .PORTS_PER_SLOT(PORTS_PER_SLOT),
        .SLOT_REG_TAB(SLOT_REG_TAB), .SLOT_OFF_TAB(SLOT_OFF_TAB)
    ) u_clr_dec (
        .vld(clr_vld), .slot(clr_slot), .port(clr_port), .mask(clr_mask)
    );

    netirq_status #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_status (
        .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask), .words(words)
    );

    netirq_regif #(
        .NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
        .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE)
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .words(words),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_pend
        assign pend[r] = ~&words[r*WORD_W +: WORD_W];
    end

    typedef struct packed {
        logic irq;
    } top_t;

    top_t top_d, top_q;

    always_comb begin
        top_d     = top_q;
        top_d.irq = |pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q.irq <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

    assign irq = top_q.irq;

    a_r5_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (words != '1) |=> irq);

    a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (words == '1) |=> !irq);

    a_r8_stray_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld && (int'(set_slot) >= int'(NUM_SLOTS)) && !clr_vld) |=> $stable(words));

endmodule

// File: tb/tb_netirq_agg.sv
module tb_netirq_agg;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        set_vld, clr_vld, rd_en;
    logic [1:0]  set_slot, clr_slot;
    logic [4:0]  set_port, clr_port;
    logic [7:0]  rd_addr;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    netirq_agg dut (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_slot(set_slot), .set_port(set_port),
        .clr_vld(clr_vld), .clr_slot(clr_slot), .clr_port(clr_port),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic        sv;
        logic [1:0]  ss;
        logic [4:0]  sp;
        logic        cv;
        logic [1:0]  cs;
        logic [4:0]  cp;
        logic [15:0] w0;
        logic [15:0] w1;
        logic        irq;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd0, 5'd3,  1'b0, 2'd0, 5'd0,  16'hFFF7, 16'hFFFF, 1'b1}, // R2 slot0
        '{1'b1, 2'd1, 5'd15, 1'b0, 2'd0, 5'd0,  16'hFFF7, 16'h7FFF, 1'b1}, // R2 slot1
        '{1'b0, 2'd0, 5'd0,  1'b1, 2'd0, 5'd3,  16'hFFFF, 16'h7FFF, 1'b1}, // R3
        '{1'b1, 2'd0, 5'd0,  1'b1, 2'd0, 5'd0,  16'hFFFE, 16'h7FFF, 1'b1}, // R4 same bit
        '{1'b1, 2'd1, 5'd1,  1'b1, 2'd1, 5'd15, 16'hFFFE, 16'hFFFD, 1'b1}, // R4 distinct bits
        '{1'b1, 2'd2, 5'd4,  1'b0, 2'd0, 5'd0,  16'hFFFE, 16'hFFFD, 1'b1}, // R8 slot
        '{1'b1, 2'd0, 5'd20, 1'b0, 2'd0, 5'd0,  16'hFFFE, 16'hFFFD, 1'b1}, // R8 port
        '{1'b0, 2'd0, 5'd0,  1'b1, 2'd0, 5'd0,  16'hFFFF, 16'hFFFD, 1'b1}, // R3
        '{1'b0, 2'd0, 5'd0,  1'b1, 2'd1, 5'd1,  16'hFFFF, 16'hFFFF, 1'b0}, // R5 fall
        '{1'b0, 2'd0, 5'd0,  1'b1, 2'd3, 5'd2,  16'hFFFF, 16'hFFFF, 1'b0}  // R8 retire slot
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] addr, output logic [15:0] data);
        rd_en   = 1'b1;
        rd_addr = addr;
        tick();
        rd_en   = 1'b0;
        data    = rd_data;
    endtask

    task automatic raise(input logic [1:0] s, input logic [4:0] p);
        set_vld = 1'b1; set_slot = s; set_port = p;
        tick();
        set_vld = 1'b0;
    endtask

    task automatic retire(input logic [1:0] s, input logic [4:0] p);
        clr_vld = 1'b1; clr_slot = s; clr_port = p;
        tick();
        clr_vld = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] hold;
        rst_n = 1'b0;
        set_vld = 1'b0; clr_vld = 1'b0; rd_en = 1'b0;
        set_slot = '0; set_port = '0; clr_slot = '0; clr_port = '0;
        rd_addr = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 rd_data", rd_data, 16'd0);
        do_read(8'h26, d); check("R1 word0", d, 16'hFFFF);
        do_read(8'h28, d); check("R1 word1", d, 16'hFFFF);

        // Vector table: R2 R3 R4 R5 R8
        for (int i = 0; i < NVEC; i++) begin
            set_vld = VEC[i].sv; set_slot = VEC[i].ss; set_port = VEC[i].sp;
            clr_vld = VEC[i].cv; clr_slot = VEC[i].cs; clr_port = VEC[i].cp;
            tick();
            set_vld = 1'b0; clr_vld = 1'b0;
            do_read(8'h26, d); check($sformatf("R2/R3/R4/R8 vec%0d word0", i), d, VEC[i].w0);
            check($sformatf("R5 vec%0d irq", i), {15'd0, irq}, {15'd0, VEC[i].irq});
            do_read(8'h28, d); check($sformatf("R2/R3/R4/R8 vec%0d word1", i), d, VEC[i].w1);
        end

        // R5 exact latency of irq
        set_vld = 1'b1; set_slot = 2'd0; set_port = 5'd2;
        tick();
        set_vld = 1'b0;
        check("R5 irq not yet high", {15'd0, irq}, 16'd0);
        tick();
        check("R5 irq high", {15'd0, irq}, 16'd1);

        // R7 repeated reads leave state alone
        do_read(8'h26, d); check("R7 read a", d, 16'hFFFB);
        do_read(8'h26, d); check("R7 read b", d, 16'hFFFB);
        check("R7 irq kept", {15'd0, irq}, 16'd1);

        // R6 unmapped address and hold
        do_read(8'h27, d); check("R6 unmapped", d, 16'd0);
        do_read(8'h26, hold);
        rd_addr = 8'h28;
        tick(); tick();
        check("R6 hold without read", rd_data, hold);
        do_read(8'h00, d); check("R6 unmapped low", d, 16'd0);

        clr_vld = 1'b1; clr_slot = 2'd0; clr_port = 5'd2;
        tick();
        clr_vld = 1'b0;
        check("R5 irq not yet low", {15'd0, irq}, 16'd1);
        tick();
        check("R5 irq low", {15'd0, irq}, 16'd0);

        // R8 stray retire on slot 2 must not touch pending bits
        raise(2'd1, 5'd0);
        retire(2'd2, 5'd0);
        do_read(8'h28, d); check("R8 stray retire", d, 16'hFFFE);
        retire(2'd1, 5'd0);
        do_read(8'h28, d); check("R3 final retire", d, 16'hFFFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule